// File: doc/BRIEF.md
# Byte-Lane Population Count Reducer

This block counts the set bits in a stream of wide data vectors. Every byte of an accepted vector is split into its two 4-bit halves. Each half indexes a 16-entry count table, and the two looked-up values are added to give that byte's bit count. The byte counts are not reduced across the vector right away. They are added into narrow 8-bit per-byte accumulators, one per byte position.

The horizontal reduction is deferred. Only after a configurable number of vectors, or when the stream ends, are the eight byte accumulators of each 64-bit lane summed into a wide lane accumulator. The flush interval is bounded so that a byte accumulator can never wrap.

When the vector marked as the last of a stream is accepted, any partly filled byte accumulators are flushed regardless of the interval. The four lane counts and their grand total are then published on the next cycle. The accumulators are cleared so that the following stream starts from zero. A typical use is sizing a bitset or scoring set overlap, after some other logic has combined two operands into one vector stream.

Top module: `pc_byte_lane_reducer`

## Requirements
- R1: The count of a byte is the table value of its low 4 bits plus the table value of its high 4 bits. The table gives the number of ones in each 4-bit value, so every byte value 0..255 is counted exactly.
- R2: Lane k of `lane_cnt_o` (bits 64k+63..64k) is the number of ones in bits 64k+63..64k of all vectors of the stream. `total_o` is the sum of the four lanes.
- R3: Every per-byte count lies in 0..8. A per-byte accumulator never holds more than 8 times the number of vectors added since its last flush.
- R4: The byte accumulators are flushed into the lane accumulators after every FLUSH_N accepted vectors, so they never wrap. Streams of any length, including all-ones streams longer than 31 vectors, are counted exactly.
- R5: An accepted vector with `in_last` high flushes all pending byte accumulators, even when fewer than FLUSH_N vectors are pending.
- R6: `done_o` is high for exactly the one cycle after an accepted last vector. `lane_cnt_o` and `total_o` change only at that point and hold their values until the next stream ends.
- R7: A cycle with `in_valid` low has no effect, whatever `in_data` and `in_last` carry.
- R8: After reset `lane_cnt_o` and `total_o` are zero and `done_o` is low.
- R9: Each stream is counted from zero. Nothing from an earlier stream carries into the next.
- R10: FLUSH_N is limited to 1..31 and checked at elaboration, since 8·31 = 248 is the largest multiple of 8 that fits in 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is present this cycle |
| in_last | input | 1 | Present vector ends the stream |
| in_data | input | VEC_W (256) | Data vector |
| lane_cnt_o | output | VEC_W (256) | Four 64-bit lane counts of the last finished stream |
| total_o | output | LANE_W (64) | Sum of the four lane counts |
| done_o | output | 1 | One-cycle pulse: results updated |

## Verification
The hardest case to reach is a byte accumulator sitting at its ceiling just as a flush is due. Only long runs of all-ones vectors drive every byte to 8 counts per vector. The stimulus therefore sends all-ones streams of 8, 16, 17 and 40 vectors, which land exactly on, just past and far beyond the flush boundary, and a 5-vector stream that ends mid-interval. A byte-value walk stream presents every value 0..255 across its vectors, so every entry of the nibble table is used. Idle cycles with random data and a stray last flag are mixed between vectors.

// File: rtl/pc_pkg.sv
package pc_pkg;

   // number of ones in each 4-bit value, packed 4 bits per entry
   function automatic logic [63:0] nib_table();
      logic [63:0] t;
      t = '0;
      for (int n = 0; n < 16; n++) begin
         t[n*4 +: 4] = 4'((n & 1) + ((n >> 1) & 1) + ((n >> 2) & 1) + ((n >> 3) & 1));
      end
      return t;
   endfunction

   localparam logic [63:0] NIB_TBL = nib_table();

endpackage

// File: rtl/pc_nibble_lut.sv
module pc_nibble_lut #(
   parameter int BYTES = 32
) (
   input  logic [BYTES*8-1:0] data_i,
   output logic [BYTES*4-1:0] cnt_o
);
   import pc_pkg::*;

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      logic [3:0] lo_nib, hi_nib;
      logic [3:0] lo_cnt, hi_cnt;
      assign lo_nib = data_i[b*8 +: 4];
      assign hi_nib = data_i[b*8+4 +: 4];
      assign lo_cnt = NIB_TBL[lo_nib*4 +: 4];
      assign hi_cnt = NIB_TBL[hi_nib*4 +: 4];
      assign cnt_o[b*4 +: 4] = lo_cnt + hi_cnt;
   end

endmodule

// File: rtl/pc_lane_reduce.sv
module pc_lane_reduce #(
   parameter int BPL    = 8,
   parameter int ACC_W  = 8,
   parameter int LANE_W = 64
) (
   input  logic [BPL*ACC_W-1:0] bytes_i,
   output logic [LANE_W-1:0]    sum_o
);

   always_comb begin
      sum_o = '0;
      for (int i = 0; i < BPL; i++) begin
         sum_o = sum_o + LANE_W'(bytes_i[i*ACC_W +: ACC_W]);
      end
   end

endmodule

// File: rtl/pc_byte_lane_reducer.sv
module pc_byte_lane_reducer #(
   parameter int VEC_W   = 256,
   parameter int LANE_W  = 64,
   parameter int FLUSH_N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic [VEC_W-1:0]  in_data,
   output logic [VEC_W-1:0]  lane_cnt_o,
   output logic [LANE_W-1:0] total_o,
   output logic              done_o
);
   localparam int LANES = VEC_W / LANE_W;
   localparam int BYTES = VEC_W / 8;
   localparam int BPL   = LANE_W / 8;
   localparam int ACC_W = 8;
   localparam int CW    = $clog2(FLUSH_N + 1);

   // elaboration checks (R10)
   if (FLUSH_N < 1 || FLUSH_N > 31) begin : g_bad_flush
      $error("FLUSH_N must lie in 1..31 (R10)");
   end
   if (VEC_W % LANE_W != 0 || LANE_W % 8 != 0) begin : g_bad_width
      $error("VEC_W must be a multiple of LANE_W, LANE_W a multiple of 8");
   end

   logic [BYTES*4-1:0]     byte_cnt;
   logic [BYTES*ACC_W-1:0] byte_acc, byte_merged;
   logic [CW-1:0]          vec_cnt;
   logic [LANE_W-1:0]      lane_acc  [LANES];
   logic [LANE_W-1:0]      lane_part [LANES];
   logic [LANE_W-1:0]      lane_next [LANES];
   logic [LANE_W-1:0]      total_next;
   logic                   flush;

   pc_nibble_lut #(.BYTES(BYTES)) u_lut (
      .data_i (in_data),
      .cnt_o  (byte_cnt)
   );

   for (genvar b = 0; b < BYTES; b++) begin : g_merge
      assign byte_merged[b*ACC_W +: ACC_W] =
         byte_acc[b*ACC_W +: ACC_W] + ACC_W'(byte_cnt[b*4 +: 4]);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      pc_lane_reduce #(.BPL(BPL), .ACC_W(ACC_W), .LANE_W(LANE_W)) u_red (
         .bytes_i (byte_merged[l*BPL*ACC_W +: BPL*ACC_W]),
         .sum_o   (lane_part[l])
      );
      assign lane_next[l] = lane_acc[l] + lane_part[l];
   end

   always_comb begin
      total_next = '0;
      for (int l = 0; l < LANES; l++) total_next = total_next + lane_next[l];
   end

   assign flush = in_valid && (in_last || vec_cnt == CW'(FLUSH_N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_acc   <= '0;
         vec_cnt    <= '0;
         lane_cnt_o <= '0;
         total_o    <= '0;
         done_o     <= 1'b0;
         for (int l = 0; l < LANES; l++) lane_acc[l] <= '0;
      end else begin
         done_o <= in_valid && in_last;
         if (in_valid) begin
            if (flush) begin
               byte_acc <= '0;
               vec_cnt  <= '0;
               for (int l = 0; l < LANES; l++) begin
                  lane_acc[l] <= in_last ? '0 : lane_next[l];
               end
               if (in_last) begin
                  for (int l = 0; l < LANES; l++) lane_cnt_o[l*LANE_W +: LANE_W] <= lane_next[l];
                  total_o <= total_next;
               end
            end else begin
               byte_acc <= byte_merged;
               vec_cnt  <= vec_cnt + 1'b1;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   assert_flush_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(vec_cnt) < FLUSH_N);

   for (genvar b = 0; b < BYTES; b++) begin : g_chk
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         int'(byte_acc[b*ACC_W +: ACC_W]) <= 8 * int'(vec_cnt));
   end

   assert_last_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> (vec_cnt == '0 && byte_acc == '0));

   assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(in_valid && in_last));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(total_o) && $stable(lane_cnt_o)));

   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(vec_cnt) && $stable(byte_acc) && !done_o));

endmodule

// File: tb/sim_pc_byte_lane_reducer.sv
module sim_pc_byte_lane_reducer;
   localparam int CLK_PERIOD = 10;
   localparam int VEC_W  = 256;
   localparam int LANE_W = 64;
   localparam int FLUSH_N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0;
   logic [VEC_W-1:0] in_data = '0;
   logic [VEC_W-1:0] lane_cnt_o;
   logic [LANE_W-1:0] total_o;
   logic done_o;

   int checks = 0, errors = 0;
   logic [VEC_W-1:0]  exp_lanes_q [$];
   logic [LANE_W-1:0] exp_total_q [$];
   logic [VEC_W-1:0]  held_lanes = '0;
   logic [LANE_W-1:0] held_total = '0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_byte_lane_reducer #(.VEC_W(VEC_W), .LANE_W(LANE_W), .FLUSH_N(FLUSH_N)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_data(in_data), .lane_cnt_o(lane_cnt_o), .total_o(total_o), .done_o(done_o)
   );

   function automatic logic [VEC_W-1:0] rand_vec();
      logic [VEC_W-1:0] v;
      for (int i = 0; i < VEC_W/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // kind: 0 random, 1 all ones, 2 zeros, 3 lane 0 only, 4 byte-value walk
   function automatic logic [VEC_W-1:0] make_vec(int kind, int idx);
      logic [VEC_W-1:0] v;
      case (kind)
         0: v = rand_vec();
         1: v = '1;
         2: v = '0;
         3: begin v = '0; v[LANE_W-1:0] = '1; end
         default: for (int b = 0; b < VEC_W/8; b++) v[b*8 +: 8] = 8'(b + idx*32);
      endcase
      return v;
   endfunction

   // driver: sends a stream and pushes its expected result (R1, R2)
   task automatic send_stream(int n, int kind, int gap);
      logic [LANE_W-1:0] acc [VEC_W/LANE_W];
      logic [VEC_W-1:0]  el;
      logic [LANE_W-1:0] et;
      logic [VEC_W-1:0]  v;
      for (int l = 0; l < VEC_W/LANE_W; l++) acc[l] = '0;
      for (int i = 0; i < n; i++) begin
         v = make_vec(kind, i);
         for (int l = 0; l < VEC_W/LANE_W; l++) acc[l] = acc[l] + LANE_W'($countones(v[l*LANE_W +: LANE_W]));
         if (i == n-1) begin
            et = '0;
            for (int l = 0; l < VEC_W/LANE_W; l++) begin el[l*LANE_W +: LANE_W] = acc[l]; et = et + acc[l]; end
            exp_lanes_q.push_back(el);
            exp_total_q.push_back(et);
         end
         @(negedge clk);
         in_valid = 1'b1; in_data = v; in_last = (i == n-1);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0; in_data = rand_vec(); in_last = 1'b1;  // ignored (R7)
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   // monitor: scoreboard compare and hold checks (R6)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_o) begin
            checks++;
            if (exp_total_q.size() == 0) begin
               errors++;
               $display("FAIL R6: done_o with no stream ended, total=%0d expected no pulse", total_o);
            end else begin
               held_lanes = exp_lanes_q.pop_front();
               held_total = exp_total_q.pop_front();
               if (lane_cnt_o !== held_lanes) begin
                  errors++;
                  $display("FAIL R2/R4/R5/R9: lanes=%h expected %h", lane_cnt_o, held_lanes);
               end
               checks++;
               if (total_o !== held_total) begin
                  errors++;
                  $display("FAIL R2: total=%0d expected %0d", total_o, held_total);
               end
            end
         end else begin
            checks++;
            if (total_o !== held_total || lane_cnt_o !== held_lanes) begin
               errors++;
               $display("FAIL R6/R7: total=%0d expected held %0d", total_o, held_total);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      checks++;
      if (total_o !== '0 || lane_cnt_o !== '0 || done_o !== 1'b0) begin
         errors++;
         $display("FAIL R8: total=%0d done=%b expected 0 0", total_o, done_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      send_stream(1, 1, 0);    // R1 single all-ones vector: 256
      send_stream(1, 2, 0);    // R9 zero stream after nonzero
      send_stream(1, 3, 0);    // R2 lane separation
      send_stream(8, 4, 0);    // R1 every byte value through the table
      send_stream(3, 0, 2);    // R7 gaps with junk and stray last
      send_stream(5, 1, 0);    // R5 partial flush on last
      send_stream(8, 1, 0);    // R4 exactly one interval
      send_stream(16, 1, 1);   // R4 two intervals
      send_stream(17, 1, 0);   // R4 one past the boundary
      send_stream(40, 1, 0);   // R4 beyond 31 vectors, R3 ceiling
      send_stream(12, 0, 0);   // R2 random
      send_stream(33, 0, 1);   // R4 random long stream with gaps
      repeat (4) @(negedge clk);
      finished = 1;
      checks++;
      if (exp_total_q.size() != 0) begin
         errors++;
         $display("FAIL R6: %0d results missing, expected 0", exp_total_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule